// File: doc/BRIEF.md
# PHY Management Serial Master (Clause 22 Framing)

This block is the bus master for the two-wire PHY management interface. It runs on a fast system clock and derives from it a free-running management clock, `mdc`. The bidirectional data line is presented as three plain signals: an output value, an output enable and an input value. A pad-level tristate buffer outside the block joins them.

A client starts a transaction on a request channel. The request carries a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The channel follows valid/ready rules. `req_ready` is high for exactly one system cycle at each management-clock falling-edge tick while the master is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. The client must therefore keep `req_valid` and the fields steady until it sees `busy`. This is the only back-pressure at the block's edge.

Each accepted request produces one complete 64-bit frame, starting with its own preamble. On a read, the master releases the line for the turnaround and the data field, and shifts the PHY's bits into `rd_data`. Completion is signalled by a one-cycle `done` pulse.

Top module: `mdio_master`

## Requirements
- R1: While `rst` is high and after it is released: `mdc` is low, `busy`, `done`, `req_ready` and `mdio_oe` are low, and `rd_data` is zero.
- R2: `mdc` toggles every DIV_HALF system cycles without pause, so its period is 2*DIV_HALF cycles. It starts low after reset.
- R3: `req_ready` is high only in the system cycle just before a falling edge of `mdc`, and only while the master is idle (not busy and not signalling done). A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high.
- R4: A frame is 64 bits, sent MSB first, with a new bit on `mdio_o` at each falling edge of `mdc`. The field order is: 32 ones, start `01`, a 2-bit opcode, the PHY address, the register address, 2 turnaround bits and 16 data bits. The first bit appears on the accepting edge.
- R5: On a read, the opcode is `10` and `mdio_oe` goes low at the start of bit 46 (the first turnaround bit). It stays low through bit 63.
- R6: On a write, the opcode is `01`, the turnaround bits are driven as `10` and the data follows MSB first. `mdio_oe` stays high for all 64 bits.
- R7: On a read, `mdio_i` is sampled in the system cycle just before each rising edge of `mdc` during bits 48..63. The samples shift into `rd_data` MSB first. `rd_data` does not change outside read data bits.
- R8: `busy` is high from the accepting edge to the falling-edge tick that ends bit 63. At that tick `done` is high for exactly one system cycle with `busy` low, and `mdio_oe` goes low.
- R9: A `req_valid` raised while `busy` is high is ignored. The frame in flight is unchanged, and no new frame starts if `req_valid` is dropped before `done`.
- R10: Back-to-back transactions each begin with the full 32-bit preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line output value |
| mdio_oe | output | 1 | Line output enable |
| mdio_i | input | 1 | Line input value |

## Verification
A wrong bit index or phase inside the master shows up on `mdio_o` or `mdio_oe` at the very next falling edge of `mdc`, within 2*DIV_HALF system cycles. It is caught there because the line is compared against an independent bit queue on every system cycle. A divider fault moves `mdc` and `req_ready` within one half period. A capture fault changes `rd_data` on the cycle of the bad sample, long before `done`. A lost or doubled completion shows up as a `done` or `busy` mismatch in the cycle it happens.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_START, ST_OP, ST_PHY, ST_REG, ST_TA, ST_DATA, ST_DONE
  } mdio_state_e;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
  localparam logic [1:0] TA_RD    = 2'b11;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic tick_fall,
  output logic tick_rise
);
  localparam int CNT_W = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap      = (cnt == LAST);
  assign tick_fall = wrap & mdc;
  assign tick_rise = wrap & ~mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_fall,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic              in_rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int FRAME_BITS = PRE_BITS + 6 + 2 * ADDR_W + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int B_START    = PRE_BITS;
  localparam int B_OP       = B_START + 2;
  localparam int B_PHY      = B_OP + 2;
  localparam int B_REG      = B_PHY + ADDR_W;
  localparam int B_TA       = B_REG + ADDR_W;
  localparam int B_DATA     = B_TA + 2;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  mdio_state_e           state;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      idx_nxt;
  logic [FRAME_BITS-1:0] sh;
  logic [FRAME_BITS-1:0] frame;
  logic                  is_rd;

  function automatic mdio_state_e phase_of(input logic [IDX_W-1:0] i);
    if (i < IDX_W'(B_START))     return ST_PRE;
    else if (i < IDX_W'(B_OP))   return ST_START;
    else if (i < IDX_W'(B_PHY))  return ST_OP;
    else if (i < IDX_W'(B_REG))  return ST_PHY;
    else if (i < IDX_W'(B_TA))   return ST_REG;
    else if (i < IDX_W'(B_DATA)) return ST_TA;
    else                         return ST_DATA;
  endfunction

  assign frame = {{PRE_BITS{1'b1}}, SOF_BITS,
                  req_read ? OP_RD : OP_WR,
                  req_phy, req_reg,
                  req_read ? TA_RD : TA_WR,
                  req_read ? {DATA_W{1'b1}} : req_wdata};

  assign idx_nxt    = idx + IDX_W'(1);
  assign req_ready  = (state == ST_IDLE) & tick_fall;
  assign busy       = (state != ST_IDLE) & (state != ST_DONE);
  assign done       = (state == ST_DONE);
  assign in_rd_data = is_rd & (state == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      sh      <= '1;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (state == ST_DONE) begin
      state <= ST_IDLE;
    end else if (tick_fall) begin
      if (state == ST_IDLE) begin
        if (req_valid) begin
          state   <= ST_PRE;
          idx     <= '0;
          is_rd   <= req_read;
          mdio_o  <= frame[FRAME_BITS-1];
          sh      <= {frame[FRAME_BITS-2:0], 1'b1};
          mdio_oe <= 1'b1;
        end
      end else if (idx == IDX_LAST) begin
        state   <= ST_DONE;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end else begin
        idx     <= idx_nxt;
        state   <= phase_of(idx_nxt);
        mdio_o  <= sh[FRAME_BITS-1];
        sh      <= {sh[FRAME_BITS-2:0], 1'b1};
        mdio_oe <= ~(is_rd & (idx_nxt >= IDX_W'(B_TA)));
      end
    end
  end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_en,
  input  logic              mdio_i,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst)            rd_data <= '0;
    else if (sample_en) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_HALF = 20,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic tick_fall;
  logic tick_rise;
  logic in_rd_data;

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) i_clkgen (
    .clk       (clk),
    .rst       (rst),
    .mdc       (mdc),
    .tick_fall (tick_fall),
    .tick_rise (tick_rise)
  );

  mdio_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_BITS(PRE_BITS)) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick_fall  (tick_fall),
    .req_valid  (req_valid),
    .req_read   (req_read),
    .req_phy    (req_phy),
    .req_reg    (req_reg),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .busy       (busy),
    .done       (done),
    .in_rd_data (in_rd_data),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  mdio_rx_capture #(.DATA_W(DATA_W)) i_capture (
    .clk       (clk),
    .rst       (rst),
    .sample_en (tick_rise & in_rd_data),
    .mdio_i    (mdio_i),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !mdio_oe);

  assert_ready_idle_R3: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !busy && !done);

  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy && mdio_oe && mdio_o);

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  assert_bit_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !$stable(mdio_o)) |-> $fell(mdc));

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> $stable(rd_data));
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .rd_data   (rd_data),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int DIV = 20;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_read = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        mdio_i = 1'b1;
  logic        req_ready, busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  mdio_master #(.DIV_HALF(DIV)) i_mdio_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  bit    hung    = 0;
  bit    started = 0;
  string ctx     = "reset R1";

  // reference model state
  int          k = 0;
  bit          m_busy = 0, m_done = 0, m_rd = 0, m_o = 1, m_oe = 0;
  int          m_idx = 0;
  bit [63:0]   m_frame;
  bit [15:0]   m_rdata = '0;
  bit [15:0]   phy_val = '0;

  function automatic bit [63:0] mk_frame(bit rd, bit [4:0] p, bit [4:0] r, bit [15:0] w);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, rd ? 2'b11 : 2'b10,
            rd ? 16'hFFFF : w};
  endfunction

  function automatic bit fall_at(int kk);
    return (kk % DIV == DIV - 1) && ((kk / DIV) % 2 == 1);
  endfunction

  function automatic bit rise_at(int kk);
    return (kk % DIV == DIV - 1) && ((kk / DIV) % 2 == 0);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      k = 0; m_busy = 0; m_done = 0; m_rd = 0; m_o = 1; m_oe = 0;
      m_idx = 0; m_rdata = '0;
    end else begin
      bit tf, tr;
      tf = fall_at(k);
      tr = rise_at(k);
      if (m_done) m_done = 0;
      else begin
        if (m_busy && tr && m_rd && m_idx >= 48)
          m_rdata = {m_rdata[14:0], mdio_i};
        if (tf) begin
          if (m_busy) begin
            if (m_idx == 63) begin
              m_busy = 0; m_done = 1; m_o = 1; m_oe = 0;
            end else begin
              m_idx++;
              m_o  = m_frame[63 - m_idx];
              m_oe = !(m_rd && m_idx >= 46);
            end
          end else if (req_valid) begin
            m_busy  = 1; m_idx = 0; m_rd = req_read;
            m_frame = mk_frame(req_read, req_phy, req_reg, req_wdata);
            m_o = m_frame[63]; m_oe = 1;
          end
        end
      end
      k++;
    end
    started <= 1'b1;
  end

  task automatic cmp(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t got %h expected %h", tag, ctx, $time, got, exp);
    end
  endtask

  // responder and per-cycle comparison
  always @(negedge clk) begin
    if (m_busy && m_rd && m_idx >= 47)
      mdio_i <= (m_idx == 47) ? 1'b0 : phy_val[63 - m_idx];
    else
      mdio_i <= 1'b1;
    if (started && !hung) begin
      cmp("R2 mdc", 16'(mdc), 16'((k / DIV) % 2));
      cmp("R3 req_ready", 16'(req_ready), 16'(!rst && !m_busy && !m_done && fall_at(k)));
      cmp("R8 busy", 16'(busy), 16'(m_busy));
      cmp("R8 done", 16'(done), 16'(m_done));
      cmp(m_rd ? "R5 mdio_oe" : "R6 mdio_oe", 16'(mdio_oe), 16'(m_oe));
      if (m_oe) cmp(m_rd ? "R4 mdio_o" : "R6 mdio_o", 16'(mdio_o), 16'(m_o));
      cmp("R7 rd_data", rd_data, m_rdata);
    end
  end

  always @(posedge clk) if (cycles == WD_LIMIT && !hung) hung <= 1'b1;

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n && !hung; i++) @(negedge clk);
  endtask

  task automatic do_req(input bit rd, input bit [4:0] p, input bit [4:0] r,
                        input bit [15:0] w, input bit [15:0] pv, input bit intrude);
    @(negedge clk);
    phy_val   = pv;
    req_read  = rd; req_phy = p; req_reg = r; req_wdata = w;
    req_valid = 1'b1;
    while (!busy && !hung) @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      // R9: a different request raised mid-frame must change nothing
      wait_cycles(300);
      req_read = !rd; req_phy = ~p; req_reg = ~r; req_wdata = ~w;
      req_valid = 1'b1;
      wait_cycles(400);
      req_valid = 1'b0;
    end
    while (!done && !hung) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    wait_cycles(6);
    rst = 1'b0;
    ctx = "after reset R1";
    wait_cycles(50);
    ctx = "read R4 R5 R7";
    do_req(1'b1, 5'h01, 5'h01, 16'h0000, 16'h796D, 1'b0);
    wait_cycles(30);
    ctx = "write R6";
    do_req(1'b0, 5'h1F, 5'h10, 16'hA5C3, 16'h0000, 1'b0);
    ctx = "read with intruding request R9";
    do_req(1'b1, 5'h01, 5'h10, 16'h0000, 16'h0015, 1'b1);
    wait_cycles(200);
    ctx = "back-to-back R10";
    do_req(1'b1, 5'h01, 5'h02, 16'h0000, 16'h2000, 1'b0);
    do_req(1'b1, 5'h01, 5'h03, 16'h0000, 16'h5C90, 1'b0);
    ctx = "write extremes R6";
    do_req(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b0);
    do_req(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 1'b0);
    ctx = "read all ones R7";
    do_req(1'b1, 5'h15, 5'h0A, 16'h0000, 16'hFFFF, 1'b0);
    wait_cycles(100);
    if (hung) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer than %0d", cycles, WD_LIMIT);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule